// File: doc/BRIEF.md
# Clock Multiplier Lock-Up Controller

This block is the digital control around a times-four clock multiplier in a microcontroller clock generator. Software reaches it through two byte-wide registers on a simple register bus. A two-bit mode field in the first register stops the multiplier, starts it, or moves the system clock onto its output. When the multiplier starts, a lock-up timer counts a power-of-two number of high-speed oscillator cycles. A read-only flag stays set until that count runs out. Only after the flag has cleared may software request the switch to the multiplied clock. Everything runs on the oscillator clock.

The analog multiplier is outside the block. It appears as an enable output and a behavioural ready input. The glitch-free clock mux is also outside the block; this block drives only its select line. The second register holds the lock-up length select and a two-bit prescaler source field. That field chooses between the CPU clock divided by 4 and the fc clock divided by 16 for the timer and serial prescalers.

Top module: `clkmul_lockup_ctrl`

## Requirements
- R1: After reset, mult_en_o, clk_sel_o and presc_fc_o are 0, and both registers read 0x00.
- R2: A write of mode code 01 into bits [7:6] of register 0 (address BASE_ADDR) sets mult_en_o and sets the lock-up flag (register 0 bit 5). clk_sel_o stays 0.
- R3: The flag stays 1 for exactly 2^(LOCK_EXP_MIN+k) clock cycles after the write edge, then reads 0. k comes from register 1 bits [1:0]: code 00 gives k=0, code 01 gives k=1, and codes 10 and 11 give k=2.
- R4: A write of mode code 10 sets clk_sel_o to 1, and mode then reads 10, if all of these hold: the current mode is 01, the flag is 0, and mult_ready_i is 1. mult_en_o stays 1.
- R5: A write of mode code 10 has no effect on clk_sel_o or on the mode read back in any of these cases: the flag is still 1, mult_ready_i is 0, or the current mode is 00.
- R6: A write of mode code 00 clears mult_en_o, clk_sel_o and the flag at the next edge. It also clears the lock-up count, including while a count is in progress.
- R7: A write of mode code 01 while a count is in progress restarts the count from zero. The same write made in mode 10 returns clk_sel_o to 0 and starts a new count with mult_en_o still 1.
- R8: Register 0 reads the mode in bits [7:6] and the live flag in bit 5. Register 1 (BASE_ADDR+1) reads the prescaler field in bits [7:6] and the length select in bits [1:0]. All other bits read 0, and any other address reads 0x00.
- R9: presc_fc_o is 1 (fc/16 source) only while register 1 bits [7:6] hold code 01. For codes 00, 10 and 11 it is 0 (CPU clock divided by 4).
- R10: A write of mode code 11 is ignored. Writes to addresses other than the two registers are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| mult_ready_i | input | 1 | Behavioural ready indication from the multiplier |
| mult_en_o | output | 1 | Multiplier enable |
| clk_sel_o | output | 1 | System clock select: 0 = oscillator path, 1 = multiplied path |
| presc_fc_o | output | 1 | Prescaler source: 0 = CPU clock/4, 1 = fc/16 |

## Verification
The bench builds the block with LOCK_EXP_MIN set to 3. This makes the three lock-up lengths 8, 16 and 32 cycles. Each length can then be counted edge by edge, and the bench checks that the flag is still set one cycle before the end and cleared on the final edge. The short lengths also leave room to land early switch requests, restarts and stops at chosen points inside a running count. The address map keeps its default base of 0xE8.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSV  = 2'b11
  } mode_e;

  localparam int FLAG_BIT = 5;

  // length select code -> exponent offset above the minimum
  function automatic int unsigned lock_step(input logic [1:0] sel);
    case (sel)
      2'b00:   lock_step = 0;
      2'b01:   lock_step = 1;
      default: lock_step = 2;
    endcase
  endfunction
endpackage

// File: rtl/clkmul_lock_timer.sv
module clkmul_lock_timer
  import clkmul_pkg::*;
#(
  parameter int LOCK_EXP_MIN = 10,
  localparam int CNT_W = LOCK_EXP_MIN + 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] len_sel_i,
  output logic       busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic             busy_q;

  always_comb begin
    len_m1 = CNT_W'((64'd1 << (LOCK_EXP_MIN + lock_step(len_sel_i))) - 64'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      // >= covers a length select lowered mid-count
      if (cnt_q >= len_m1) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> busy_q && cnt_q == '0);
  p_stop_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_q && cnt_q == '0);
  p_flag_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && !$past(stop_i) |-> $past(cnt_q) >= $past(len_m1));
endmodule

// File: rtl/clkmul_mode_ctrl.sv
module clkmul_mode_ctrl
  import clkmul_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wmode_i,
  input  logic       busy_i,
  input  logic       ready_i,
  output logic [1:0] mode_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       mult_en_o,
  output logic       clk_sel_o
);
  mode_e mode_q;
  logic  en_q, sel_q, switch_ok;

  assign start_o   = wr_i && (wmode_i == MODE_LOCK);
  assign stop_o    = wr_i && (wmode_i == MODE_OFF);
  assign switch_ok = wr_i && (wmode_i == MODE_RUN) && (mode_q == MODE_LOCK)
                     && !busy_i && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else if (stop_o) begin
      mode_q <= MODE_OFF;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else if (start_o) begin
      mode_q <= MODE_LOCK;
      en_q   <= 1'b1;
      sel_q  <= 1'b0;
    end else if (switch_ok) begin
      mode_q <= MODE_RUN;
      sel_q  <= 1'b1;
    end
  end

  assign mode_o    = mode_q;
  assign mult_en_o = en_q;
  assign clk_sel_o = sel_q;

  p_sel_after_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q) |-> !$past(busy_i) && $past(ready_i) && $past(mode_q) == MODE_LOCK);
  p_early_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wmode_i == MODE_RUN && busy_i |=> !sel_q);
  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !en_q && !sel_q);
  p_sel_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q |-> en_q);
  p_busy_not_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> mode_q == MODE_LOCK);
endmodule

// File: rtl/clkmul_regs.sv
module clkmul_regs
  import clkmul_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'hE8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        mode_i,
  input  logic              busy_i,
  output logic              ctrl_wr_o,
  output logic [1:0]        wmode_o,
  output logic [1:0]        len_sel_o,
  output logic [1:0]        presc_o,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_PARM = ADDR_W'(BASE_ADDR) + 1'b1;

  logic [1:0] len_q, presc_q;
  logic       hit_ctrl, hit_parm;

  assign hit_ctrl = (addr_i == A_CTRL);
  assign hit_parm = (addr_i == A_PARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= 2'b00;
      presc_q <= 2'b00;
    end else if (we_i && hit_parm) begin
      len_q   <= wdata_i[1:0];
      presc_q <= wdata_i[7:6];
    end
  end

  assign ctrl_wr_o = we_i && hit_ctrl;
  assign wmode_o   = wdata_i[7:6];
  assign len_sel_o = len_q;
  assign presc_o   = presc_q;

  always_comb begin
    rdata_o = 8'h00;
    if (hit_ctrl) begin
      rdata_o[7:6]      = mode_i;
      rdata_o[FLAG_BIT] = busy_i;
    end else if (hit_parm) begin
      rdata_o[7:6] = presc_q;
      rdata_o[1:0] = len_q;
    end
  end

  p_parm_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && hit_parm |=> len_q == $past(wdata_i[1:0]) && presc_q == $past(wdata_i[7:6]));
endmodule

// File: rtl/clkmul_lockup_ctrl.sv
module clkmul_lockup_ctrl
  import clkmul_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter logic [7:0] BASE_ADDR    = 8'hE8,
  parameter int         LOCK_EXP_MIN = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              mult_ready_i,
  output logic              mult_en_o,
  output logic              clk_sel_o,
  output logic              presc_fc_o
);
  logic       ctrl_wr, start, stop, busy;
  logic [1:0] wmode, len_sel, presc, mode;

  clkmul_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .mode_i(mode), .busy_i(busy),
    .ctrl_wr_o(ctrl_wr), .wmode_o(wmode), .len_sel_o(len_sel),
    .presc_o(presc), .rdata_o
  );

  clkmul_mode_ctrl u_mode (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .wmode_i(wmode), .busy_i(busy),
    .ready_i(mult_ready_i), .mode_o(mode), .start_o(start), .stop_o(stop),
    .mult_en_o, .clk_sel_o
  );

  clkmul_lock_timer #(.LOCK_EXP_MIN(LOCK_EXP_MIN)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop),
    .len_sel_i(len_sel), .busy_o(busy)
  );

  assign presc_fc_o = (presc == 2'b01);

  p_presc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_fc_o |-> rdata_o[7:6] == 2'b01 || addr_i != ADDR_W'(BASE_ADDR) + 1'b1);
endmodule

// File: tb/tb_clkmul_lockup_ctrl.sv
module tb_clkmul_lockup_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_MIN    = 3;
  localparam logic [7:0] A0 = 8'hE8;
  localparam logic [7:0] A1 = 8'hE9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ready = 1'b1;
  logic       mult_en, clk_sel, presc_fc;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmul_lockup_ctrl #(.ADDR_W(8), .BASE_ADDR(8'hE8), .LOCK_EXP_MIN(EXP_MIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mult_ready_i(ready), .mult_en_o(mult_en),
    .clk_sel_o(clk_sel), .presc_fc_o(presc_fc)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; consumes exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 mult_en", {7'd0, mult_en}, 8'h00);
    chk("R1 clk_sel", {7'd0, clk_sel}, 8'h00);
    chk("R1 presc", {7'd0, presc_fc}, 8'h00);
    rd(A0, v); chk("R1 reg0", v, 8'h00);
    rd(A1, v); chk("R1 reg1", v, 8'h00);
  endtask

  task automatic t_lock_len(input logic [1:0] sel, input int len);
    logic [7:0] v;
    wr(A1, {6'd0, sel});
    wr(A0, 8'h40);
    rd(A0, v); chk("R2 flag set", v, 8'h60);
    chk("R2 mult_en", {7'd0, mult_en}, 8'h01);
    chk("R2 clk_sel", {7'd0, clk_sel}, 8'h00);
    tick(len - 1);
    rd(A0, v); chk("R3 flag before end", v, 8'h60);
    tick(1);
    rd(A0, v); chk("R3 flag cleared", v, 8'h40);
    wr(A0, 8'h00);
  endtask

  task automatic t_switch();
    logic [7:0] v;
    ready = 1'b1;
    wr(A1, 8'h0B);
    wr(A0, 8'h40);
    tick(32);
    wr(A0, 8'h80);
    rd(A0, v); chk("R4 mode run", v, 8'h80);
    chk("R4 clk_sel", {7'd0, clk_sel}, 8'h01);
    chk("R4 mult_en", {7'd0, mult_en}, 8'h01);
    wr(A0, 8'h00);
    rd(A0, v); chk("R6 reg0 off", v, 8'h00);
    chk("R6 mult_en", {7'd0, mult_en}, 8'h00);
    chk("R6 clk_sel", {7'd0, clk_sel}, 8'h00);
  endtask

  task automatic t_early();
    logic [7:0] v;
    wr(A1, 8'h00);
    wr(A0, 8'h40);
    tick(3);
    wr(A0, 8'h80);
    rd(A0, v); chk("R5 early switch", v, 8'h60);
    chk("R5 early clk_sel", {7'd0, clk_sel}, 8'h00);
    tick(4);
    rd(A0, v); chk("R5 lock done", v, 8'h40);
    ready = 1'b0;
    wr(A0, 8'h80);
    rd(A0, v); chk("R5 not ready", v, 8'h40);
    chk("R5 not ready clk_sel", {7'd0, clk_sel}, 8'h00);
    ready = 1'b1;
    wr(A0, 8'h00);
    wr(A0, 8'h80);
    rd(A0, v); chk("R5 from off", v, 8'h00);
    chk("R5 from off clk_sel", {7'd0, clk_sel}, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    wr(A1, 8'h00);
    wr(A0, 8'h40);
    tick(5);
    wr(A0, 8'h40);
    tick(7);
    rd(A0, v); chk("R7 restarted flag", v, 8'h60);
    tick(1);
    rd(A0, v); chk("R7 restarted end", v, 8'h40);
    wr(A0, 8'h80);
    chk("R4 run before restart", {7'd0, clk_sel}, 8'h01);
    wr(A0, 8'h40);
    rd(A0, v); chk("R7 from run", v, 8'h60);
    chk("R7 clk_sel back", {7'd0, clk_sel}, 8'h00);
    chk("R7 mult_en kept", {7'd0, mult_en}, 8'h01);
    tick(2);
    wr(A0, 8'h00);
    rd(A0, v); chk("R6 stop mid-count", v, 8'h00);
    wr(A0, 8'h40);
    tick(7);
    rd(A0, v); chk("R6 count cleared", v, 8'h60);
    tick(1);
    rd(A0, v); chk("R6 count full len", v, 8'h40);
    wr(A0, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(A0, 8'hC0);
    rd(A0, v); chk("R10 code11 off", v, 8'h00);
    chk("R10 code11 en", {7'd0, mult_en}, 8'h00);
    wr(8'hE7, 8'h40);
    wr(8'hEA, 8'h40);
    rd(A0, v); chk("R10 stray addr", v, 8'h00);
    chk("R10 stray en", {7'd0, mult_en}, 8'h00);
    wr(A0, 8'h40);
    tick(8);
    wr(A0, 8'hC0);
    rd(A0, v); chk("R10 code11 lock", v, 8'h40);
    chk("R10 code11 en kept", {7'd0, mult_en}, 8'h01);
    wr(A0, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(A1, 8'hFF);
    rd(A1, v); chk("R8 reg1 mask", v, 8'hC3);
    rd(8'hEA, v); chk("R8 other addr", v, 8'h00);
    wr(A1, 8'h00);
    wr(A0, 8'h5F);
    rd(A0, v); chk("R8 reg0 mask", v, 8'h60);
    wr(A0, 8'h00);
  endtask

  task automatic t_presc();
    wr(A1, 8'h40); chk("R9 code01", {7'd0, presc_fc}, 8'h01);
    wr(A1, 8'h80); chk("R9 code10", {7'd0, presc_fc}, 8'h00);
    wr(A1, 8'hC0); chk("R9 code11", {7'd0, presc_fc}, 8'h00);
    wr(A1, 8'h00); chk("R9 code00", {7'd0, presc_fc}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_len(2'b00, 8);
    t_lock_len(2'b01, 16);
    t_lock_len(2'b10, 32);
    t_lock_len(2'b11, 32);
    t_switch();
    t_early();
    t_restart();
    t_ignored();
    t_readback();
    t_presc();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule